// File: doc/BRIEF.md
# Pipelined Memory Bus Slave

This block answers a simple synchronous memory bus. A master holds a request line high together with a direction bit, a per-byte enable mask, a word address and write data. The slave holds an internal register file. It answers each request with a one-clock acknowledge. Before that acknowledge it can insert a fixed number of wait states, set by a parameter.

Reads are pipelined. The word that was read is presented one clock after its acknowledge and stays there until the next read is acknowledged. Because of this the master can issue a write in the very clock that returns the previous read. An address beyond the register file is acknowledged with an error flag. Such an access leaves the storage untouched and reads back as zero. While the block is held in reset, the error flag is high.

Top module: `pipeMemSlave`

## Requirements
- R1: While `rst` is high, `busAck` is 0 and `busErr` is 1. After reset, `rdData` reads 0 until the first read is acknowledged.
- R2: Outside reset, with `busReq` low, both `busAck` and `busErr` are 0 (idle cycle).
- R3: A request held on `busReq` is acknowledged for exactly one clock, in its (WAIT_STATES+1)-th consecutive cycle. `busAck` stays 0 in the earlier cycles. WAIT_STATES may be 0 to 3, and 0 acknowledges in the first cycle.
- R4: On an acknowledged in-range write, bit b of `byteEn` writes bits 8b+7..8b of `wrData` into the addressed word. The bytes whose enable is 0 keep their old value.
- R5: For an acknowledged in-range read, `rdData` shows the addressed word in the clock after the acknowledge. `byteEn` has no effect on reads.
- R6: `rdData` changes only in the clock after a read acknowledge. It holds its value through idle cycles and through write cycles.
- R7: Word addresses at or above DEPTH are out of range. An out-of-range access gets `busErr`=1 in the same clock as `busAck`. Outside reset, `busErr` is never 1 without `busAck`.
- R8: An out-of-range write does not change any stored word.
- R9: An out-of-range read returns 0 on `rdData` in the clock after its acknowledge.
- R10: A write issued in the clock right after a read acknowledge is accepted normally. During that same clock, `rdData` carries the read result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| busReq | input | 1 | Request valid |
| busWrite | input | 1 | 1 = write, 0 = read |
| byteEn | input | DATA_W/8 | Byte enables for writes |
| busAddr | input | ADDR_W | Word address |
| wrData | input | DATA_W | Write data |
| busAck | output | 1 | Request acknowledge |
| rdData | output | DATA_W | Read data, one clock after the read acknowledge |
| busErr | output | 1 | Error flag, valid together with the acknowledge and high in reset |

## Verification
`busAck` and `busErr` are combinational on the request. The bench drives each request on a falling edge and samples these two outputs 1 ns later, in every cycle of the request. It expects the acknowledge only in cycle WAIT_STATES+1. `rdData` is due one rising edge after the acknowledge, so it is checked at the next falling edge. It is checked again at the start of the following write or idle cycle, which shows that the value holds. A bench-side word model, updated byte by byte from each write's enables, supplies every expected read value. Sweeps cover all addresses, all enable masks and several out-of-range addresses.

// File: rtl/pipeMemPkg.sv
package pipeMemPkg;
  typedef struct packed {
    logic wrEn;   // commit write data into the array
    logic rdEn;   // load the read register
    logic rdOor;  // read is out of range: load zero
  } memStrb_t;
endpackage

// File: rtl/pipeMemCtrl.sv
module pipeMemCtrl
  import pipeMemPkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DEPTH       = 16,
  parameter int WAIT_STATES = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busReq,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output logic              busAck,
  output logic              busErr,
  output memStrb_t          strb
);
  localparam logic [1:0]      WAIT_L = 2'(WAIT_STATES);
  localparam logic [ADDR_W:0] LIMIT  = (ADDR_W+1)'(DEPTH);

  logic [1:0] waitCnt;
  logic       outOfRange;

  assign outOfRange = ({1'b0, busAddr} >= LIMIT);
  assign busAck     = busReq && !rst && (waitCnt == WAIT_L);
  assign busErr     = rst || (busAck && outOfRange);

  always_ff @(posedge clk) begin
    if (rst)              waitCnt <= '0;
    else if (busAck)      waitCnt <= '0;
    else if (busReq)      waitCnt <= waitCnt + 2'd1;
    else                  waitCnt <= '0;
  end

  always_comb begin
    strb.wrEn  = busAck && busWrite && !outOfRange;
    strb.rdEn  = busAck && !busWrite;
    strb.rdOor = outOfRange;
  end

  // R3: with wait states, a request in its first cycle is never acknowledged
  p_no_early_ack_r3: assert property (@(posedge clk) disable iff (rst)
    (WAIT_STATES != 0 && busReq && !$past(busReq)) |-> !busAck);

  // R3: an acknowledge is a single-cycle pulse when wait states are used
  p_single_ack_r3: assert property (@(posedge clk) disable iff (rst)
    (WAIT_STATES != 0 && busAck) |=> !busAck);
endmodule

// File: rtl/pipeMemData.sv
module pipeMemData
  import pipeMemPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6,
  parameter int DEPTH  = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  memStrb_t            strb,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [DATA_W/8-1:0] byteEn,
  input  logic [DATA_W-1:0]   wrData,
  output logic [DATA_W-1:0]   rdData
);
  localparam int LANES = DATA_W / 8;
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] rdWord;

  assign idx = busAddr[IDX_W-1:0];

  for (genvar b = 0; b < LANES; b++) begin : gLane
    logic [7:0] laneMem [DEPTH];

    always_ff @(posedge clk) begin
      if (rst) begin
        for (int i = 0; i < DEPTH; i++) laneMem[i] <= '0;
      end else if (strb.wrEn && byteEn[b]) begin
        laneMem[idx] <= wrData[8*b +: 8];
      end
    end

    assign rdWord[8*b +: 8] = laneMem[idx];
  end

  always_ff @(posedge clk) begin
    if (rst)            rdData <= '0;
    else if (strb.rdEn) rdData <= strb.rdOor ? '0 : rdWord;
  end

  // R6: without a read strobe the read register holds its value
  p_rd_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !strb.rdEn |=> $stable(rdData));

  // R8: a write strobe only ever targets an in-range address
  p_wr_in_range_r8: assert property (@(posedge clk) disable iff (rst)
    strb.wrEn |-> (int'(busAddr) < DEPTH));
endmodule

// File: rtl/pipeMemSlave.sv
module pipeMemSlave
  import pipeMemPkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 6,
  parameter int DEPTH       = 16,
  parameter int WAIT_STATES = 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                busReq,
  input  logic                busWrite,
  input  logic [DATA_W/8-1:0] byteEn,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [DATA_W-1:0]   wrData,
  output logic                busAck,
  output logic [DATA_W-1:0]   rdData,
  output logic                busErr
);
  memStrb_t strb;

  pipeMemCtrl #(
    .ADDR_W(ADDR_W), .DEPTH(DEPTH), .WAIT_STATES(WAIT_STATES)
  ) uCtrl (
    .clk(clk), .rst(rst), .busReq(busReq), .busWrite(busWrite),
    .busAddr(busAddr), .busAck(busAck), .busErr(busErr), .strb(strb)
  );

  pipeMemData #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH)
  ) uData (
    .clk(clk), .rst(rst), .strb(strb), .busAddr(busAddr),
    .byteEn(byteEn), .wrData(wrData), .rdData(rdData)
  );

  // R7: outside reset the error flag only appears with an acknowledge
  p_err_with_ack_r7: assert property (@(posedge clk) disable iff (rst)
    busErr |-> busAck);

  // R2: idle cycle carries neither acknowledge nor error
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !busReq |-> (!busAck && !busErr));
endmodule

// File: tb/tb_pipeMemSlave.sv
module tb_pipeMemSlave;
  localparam int TB_WAIT = 2;
  localparam int DEPTH   = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        busReq = 1'b1, busWrite = 1'b0;
  logic [3:0]  byteEn = '0;
  logic [5:0]  busAddr = '0;
  logic [31:0] wrData = '0;
  logic        busAck, busErr;
  logic [31:0] rdData;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] model [DEPTH];
  logic [31:0] lastRd = '0;

  always #5 clk = ~clk;

  pipeMemSlave #(.DATA_W(32), .ADDR_W(6), .DEPTH(DEPTH), .WAIT_STATES(TB_WAIT)) dut (
    .clk(clk), .rst(rst), .busReq(busReq), .busWrite(busWrite), .byteEn(byteEn),
    .busAddr(busAddr), .wrData(wrData), .busAck(busAck), .rdData(rdData), .busErr(busErr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [5:0] a, input logic [3:0] s,
                        input logic [31:0] d);
    busReq = 1'b1; busWrite = wr; busAddr = a; byteEn = s; wrData = d;
    for (int k = 0; k <= TB_WAIT; k++) begin
      #1;
      chk("R3 ack timing", {31'b0, busAck}, {31'b0, k == TB_WAIT});
      chk("R7 err with ack", {31'b0, busErr}, {31'b0, (k == TB_WAIT) && (a >= DEPTH)});
      if (k == 0) chk("R6/R10 read data held", rdData, lastRd);
      if (k < TB_WAIT) @(negedge clk);
    end
    @(negedge clk);
    if (wr) begin
      if (a < DEPTH)
        for (int b = 0; b < 4; b++)
          if (s[b]) model[a][8*b +: 8] = d[8*b +: 8];
    end else begin
      lastRd = (a < DEPTH) ? model[a] : 32'h0;
      chk(a < DEPTH ? "R5 read data" : "R9 out-of-range read", rdData, lastRd);
    end
  endtask

  task automatic idle();
    busReq = 1'b0; busWrite = ~busWrite; busAddr = busAddr + 6'd1; wrData = ~wrData;
    #1;
    chk("R2 idle ack", {31'b0, busAck}, 32'h0);
    chk("R2 idle err", {31'b0, busErr}, 32'h0);
    chk("R6 idle hold", rdData, lastRd);
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset ack", {31'b0, busAck}, 32'h0);
    chk("R1 reset err", {31'b0, busErr}, 32'h1);
    chk("R1 reset data", rdData, 32'h0);
    @(negedge clk);
    rst = 1'b0;
    idle(); idle();
    // R4: fill every word with full enables
    for (int a = 0; a < DEPTH; a++)
      access(1'b1, 6'(a), 4'hF, 32'hA5000000 ^ (32'(a) * 32'h01030507));
    // R5: read back with enables cleared (ignored on reads)
    for (int a = 0; a < DEPTH; a++) access(1'b0, 6'(a), 4'h0, 32'h0);
    // R4: every enable mask on one word, each followed by a read (R10 back-to-back)
    for (int s = 0; s < 16; s++) begin
      access(1'b1, 6'd5, 4'(s), 32'h11223344 + 32'(s) * 32'h10101010);
      access(1'b0, 6'd5, 4'(15 - s), 32'h0);
    end
    // R7/R8: out-of-range writes leave storage unchanged
    access(1'b1, 6'd16, 4'hF, 32'hDEADBEEF);
    access(1'b1, 6'd31, 4'hF, 32'hCAFEF00D);
    access(1'b1, 6'd63, 4'hF, 32'h0BADC0DE);
    for (int a = 0; a < DEPTH; a++) access(1'b0, 6'(a), 4'hF, 32'h0);
    // R9: out-of-range reads give zero
    access(1'b0, 6'd3, 4'hF, 32'h0);
    access(1'b0, 6'd40, 4'hF, 32'h0);
    access(1'b0, 6'd7, 4'hF, 32'h0);
    access(1'b0, 6'd16, 4'hF, 32'h0);
    // R6: hold through idles, then R10 write right after a read
    access(1'b0, 6'd9, 4'hF, 32'h0);
    idle(); idle(); idle();
    access(1'b0, 6'd2, 4'hF, 32'h0);
    access(1'b1, 6'd2, 4'h3, 32'h5A5A5A5A);
    access(1'b0, 6'd2, 4'hF, 32'h0);
    idle();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog timeout");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule